// File: doc/BRIEF.md
# Memory Controller Mode and Access Gate

This block is the mode-control front end of an external memory controller. It keeps a 32-bit control word with three live fields: a controller enable, a low-power request and an address-mirror switch. It uses them to decide what happens to each memory request that arrives from the system side. When the controller is enabled and not in low power, a request is passed to the memory timing engine with a one-hot chip select. Otherwise the request is answered with an error and never reaches memory. A plain register port reads and writes the control word and a small status word at any time, in every mode.

While the mirror switch is set, requests aimed at chip select 0 or chip select 4 are steered onto chip select 1. Software normally runs with this mapping after reset and clears it to open up the other two regions. The block also tells the refresh engine whether dynamic refresh may run. Refresh continues through low power and stops only while the controller is disabled. An idle flag shows when no request is in flight. Changing enable or low power while a request is in flight still takes effect, but it leaves a sticky warning flag in the status word.

One request is handled at a time. The gating decision is taken when the request is accepted. A request that is already in flight finishes normally even if the mode changes under it.

Top module: `memctl_mode_gate`

## Requirements
- R1: After reset the control word reads 0x00000003 (enabled, mirror on, low power off), the status word reads 0, `refresh_en` is 1, and both `idle` and `req_ready` are 1.
- R2: The control word is at register address 0. Bit 0 is enable, bit 1 is mirror and bit 2 is low power. Bits 31:3 always read 0, and any value written to them is discarded.
- R3: A request accepted while enable is 0 or low power is 1 is answered with `rsp_valid`=1 and `rsp_err`=1 in the cycle after acceptance. `mem_valid` does not rise for it, and `mem_cs` stays all zero.
- R4: A request accepted while enable is 1 and low power is 0 drives `mem_valid` with a one-hot `mem_cs` from the cycle after acceptance. Both hold steady until `mem_ready`. The request is then answered with `rsp_valid`=1 and `rsp_err`=0 in the cycle in which `mem_done` is 1.
- R5: Register reads and writes take effect in the same cycle as `reg_sel` in every combination of enable and low power.
- R6: While mirror is 1, chip select indices 0 and 4 map to `mem_cs` bit 1, and every other index i maps to bit i. While mirror is 0, index i always maps to bit i.
- R7: `refresh_en` equals the enable bit, whatever the value of low power.
- R8: The gating decision is taken at acceptance. A forwarded request completes without error even if enable or low power is changed while it is in flight, and the new mode applies to the next request.
- R9: One request is handled at a time. From the cycle after acceptance until the response cycle, `idle` and `req_ready` are 0.
- R10: Status bit 0 at register address 1 is set by a control write that changes enable or low power while `idle` is 0. That write is still applied. The bit then stays set until a write to address 1 with bit 0 = 1. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address (0 control, 1 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on address |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Request can be accepted |
| req_cs | input | 3 | Decoded chip select index of the request |
| mem_valid | output | 1 | Request forwarded to the timing engine |
| mem_ready | input | 1 | Timing engine took the request |
| mem_cs | output | 8 | One-hot chip select while forwarded/in flight |
| mem_done | input | 1 | Timing engine finished the access |
| rsp_valid | output | 1 | Response to the requester |
| rsp_err | output | 1 | Response is an error |
| idle | output | 1 | No request in flight |
| refresh_en | output | 1 | Refresh engine may run |

## Verification
If the stored mode bits are wrong, the error bit on the response to the next request is wrong. That response appears either one cycle after acceptance or with `mem_done`. `refresh_en` shows a bad enable bit at once. A bad mirror bit shows up as the wrong `mem_cs` bit in the first cycle of the forwarded request. A request state that is stuck shows as `idle` staying low, or as a response that never appears or does not match the queued expectation. A lost violation record is seen on the next read of the status word.

// File: rtl/memgate_pkg.sv
package memgate_pkg;
  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_MIR_BIT = 1;
  localparam int MODE_LP_BIT  = 2;
  localparam int MODE_BITS    = 3;

  typedef struct packed {
    logic lp;
    logic mir;
    logic en;
  } mode_t;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_FWD  = 2'd1,
    GS_WAIT = 2'd2,
    GS_ERR  = 2'd3
  } gate_state_e;
endpackage

// File: rtl/memgate_rst_sync.sv
module memgate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/memgate_regs.sv
module memgate_regs
  import memgate_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idle,
  output logic [DATA_W-1:0] rdata,
  output mode_t             mode,
  output logic              viol
);
  mode_t mode_q, mode_d;
  logic  viol_q, viol_d;
  logic  ctrl_wr, stat_wr, mode_change, viol_en;

  always_comb begin
    ctrl_wr     = sel && wr && (addr == ADDR_W'(CTRL_ADDR));
    stat_wr     = sel && wr && (addr == ADDR_W'(STAT_ADDR));
    mode_d.en   = wdata[MODE_EN_BIT];
    mode_d.mir  = wdata[MODE_MIR_BIT];
    mode_d.lp   = wdata[MODE_LP_BIT];
    mode_change = ctrl_wr && !idle &&
                  ((mode_d.en != mode_q.en) || (mode_d.lp != mode_q.lp));
    viol_en     = mode_change || (stat_wr && wdata[0]);
    viol_d      = mode_change;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{lp: 1'b0, mir: 1'b1, en: 1'b1};
    end else if (ctrl_wr) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       viol_q <= 1'b0;
    else if (viol_en) viol_q <= viol_d;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdata[MODE_EN_BIT]  = mode_q.en;
      rdata[MODE_MIR_BIT] = mode_q.mir;
      rdata[MODE_LP_BIT]  = mode_q.lp;
    end else if (addr == ADDR_W'(STAT_ADDR)) begin
      rdata[0] = viol_q;
    end
  end

  assign mode = mode_q;
  assign viol = viol_q;
endmodule

// File: rtl/memgate_csmap.sv
module memgate_csmap #(
  parameter int NUM_CS     = 8,
  parameter int CS_IDX_W   = $clog2(NUM_CS),
  parameter int MIR_TARGET = 1,
  parameter int MIR_SRC_A  = 0,
  parameter int MIR_SRC_B  = 4
) (
  input  logic [CS_IDX_W-1:0] idx,
  input  logic                mirror,
  output logic [NUM_CS-1:0]   onehot
);
  logic [CS_IDX_W-1:0] mapped;

  always_comb begin
    if (mirror && (idx == CS_IDX_W'(MIR_SRC_A) || idx == CS_IDX_W'(MIR_SRC_B)))
      mapped = CS_IDX_W'(MIR_TARGET);
    else
      mapped = idx;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_dec
    assign onehot[g] = (mapped == CS_IDX_W'(g));
  end
endmodule

// File: rtl/memgate_fsm.sv
module memgate_fsm
  import memgate_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              gate_open,
  input  logic [NUM_CS-1:0] cs_in,
  input  logic              mem_ready,
  input  logic              mem_done,
  output logic              req_ready,
  output logic              mem_valid,
  output logic [NUM_CS-1:0] mem_cs,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              idle
);
  gate_state_e state_q, state_d;
  logic [NUM_CS-1:0] cs_q;
  logic accept, cs_en;

  always_comb begin
    accept  = req_valid && (state_q == GS_IDLE);
    cs_en   = accept && gate_open;
    state_d = state_q;
    unique case (state_q)
      GS_IDLE: if (accept)    state_d = gate_open ? GS_FWD : GS_ERR;
      GS_FWD:  if (mem_ready) state_d = GS_WAIT;
      GS_WAIT: if (mem_done)  state_d = GS_IDLE;
      GS_ERR:                 state_d = GS_IDLE;
      default:                state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cs_q <= '0;
    else if (cs_en) cs_q <= cs_in;
  end

  always_comb begin
    idle      = (state_q == GS_IDLE);
    req_ready = idle;
    mem_valid = (state_q == GS_FWD);
    mem_cs    = (state_q == GS_FWD || state_q == GS_WAIT) ? cs_q : '0;
    rsp_err   = (state_q == GS_ERR);
    rsp_valid = rsp_err || ((state_q == GS_WAIT) && mem_done);
  end
endmodule

// File: rtl/memctl_mode_gate.sv
module memctl_mode_gate
  import memgate_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int NUM_CS     = 8,
  parameter int CS_IDX_W   = $clog2(NUM_CS),
  parameter int MIR_TARGET = 1,
  parameter int MIR_SRC_A  = 0,
  parameter int MIR_SRC_B  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_sel,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CS_IDX_W-1:0] req_cs,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [NUM_CS-1:0]   mem_cs,
  input  logic                mem_done,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic                idle,
  output logic                refresh_en
);
  logic              rst_n_i;
  mode_t             mode;
  logic              viol;
  logic              mode_en, mode_lp, mode_mir, gate_open;
  logic [NUM_CS-1:0] cs_onehot;

  memgate_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  memgate_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(0), .STAT_ADDR(1)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .idle(idle), .rdata(reg_rdata), .mode(mode), .viol(viol)
  );

  assign mode_en    = mode.en;
  assign mode_lp    = mode.lp;
  assign mode_mir   = mode.mir;
  assign gate_open  = mode_en && !mode_lp;
  assign refresh_en = mode_en;

  memgate_csmap #(.NUM_CS(NUM_CS), .CS_IDX_W(CS_IDX_W), .MIR_TARGET(MIR_TARGET),
                  .MIR_SRC_A(MIR_SRC_A), .MIR_SRC_B(MIR_SRC_B)) u_map (
    .idx(req_cs), .mirror(mode_mir), .onehot(cs_onehot)
  );

  memgate_fsm #(.NUM_CS(NUM_CS)) u_fsm (
    .clk(clk), .rst_n(rst_n_i), .req_valid(req_valid), .gate_open(gate_open),
    .cs_in(cs_onehot), .mem_ready(mem_ready), .mem_done(mem_done),
    .req_ready(req_ready), .mem_valid(mem_valid), .mem_cs(mem_cs),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .idle(idle)
  );
endmodule

// File: rtl/memctl_mode_gate_chk.sv
module memctl_mode_gate_chk #(
  parameter int NUM_CS     = 8,
  parameter int CS_IDX_W   = 3,
  parameter int MIR_TARGET = 1,
  parameter int MIR_SRC_A  = 0,
  parameter int MIR_SRC_B  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [CS_IDX_W-1:0] req_cs,
  input logic                mode_en,
  input logic                mode_lp,
  input logic                mode_mir,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic [NUM_CS-1:0]   mem_cs,
  input logic                rsp_valid,
  input logic                rsp_err,
  input logic                idle
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R3: refused request answered next cycle, never forwarded
  a_r3_refused: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (!mode_en || mode_lp) |=> rsp_valid && rsp_err && !mem_valid);

  // R3: no chip select during an error response
  a_r3_err_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> mem_cs == '0);

  // R4: forwarded request holds until taken
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_cs));

  // R4: chip select is one-hot or empty
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_cs));

  // R6: mirrored sources land on the target select
  a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode_en && !mode_lp && mode_mir &&
    (req_cs == CS_IDX_W'(MIR_SRC_A) || req_cs == CS_IDX_W'(MIR_SRC_B))
    |=> mem_cs == (NUM_CS'(1) << MIR_TARGET));

  // R9: busy after acceptance
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !idle && !req_ready);
endmodule

bind memctl_mode_gate memctl_mode_gate_chk #(
  .NUM_CS(NUM_CS), .CS_IDX_W(CS_IDX_W), .MIR_TARGET(MIR_TARGET),
  .MIR_SRC_A(MIR_SRC_A), .MIR_SRC_B(MIR_SRC_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cs(req_cs), .mode_en(mode_en), .mode_lp(mode_lp), .mode_mir(mode_mir),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_cs(mem_cs),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .idle(idle)
);

// File: tb/memctl_mode_gate_test.sv
module memctl_mode_gate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        req_valid, req_ready;
  logic [2:0]  req_cs;
  logic        mem_valid, mem_ready, mem_done;
  logic [7:0]  mem_cs;
  logic        rsp_valid, rsp_err, idle, refresh_en;

  int nvec = 0;
  int nfail = 0;
  bit m_en, m_mir, m_lp;
  bit   err_q[$];
  logic [7:0] cs_q[$];
  int   fwd_cnt = 0;
  int   mcount = 0;

  always #5 clk = ~clk;

  memctl_mode_gate uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_cs(mem_cs),
    .mem_done(mem_done), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .idle(idle), .refresh_en(refresh_en)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // memory side model: takes the request, finishes three cycles later
  always begin
    @(negedge clk); #1;
    mem_ready = 1'b0;
    mem_done  = 1'b0;
    if (mcount > 0) begin
      mcount--;
      if (mcount == 0) mem_done = 1'b1;
    end else if (mem_valid) begin
      fwd_cnt++;
      if (cs_q.size() == 0) chk(0, "R3 unexpected forward", mem_cs, 0);
      else begin
        logic [7:0] e;
        e = cs_q.pop_front();
        chk(mem_cs == e, "R4/R6 chip select", mem_cs, e);
      end
      mem_ready = 1'b1;
      mcount = 3;
    end
  end

  // response monitor
  always begin
    @(negedge clk); #3;
    if (rsp_valid) begin
      if (err_q.size() == 0) chk(0, "R9 unexpected response", 1, 0);
      else begin
        bit e;
        e = err_q.pop_front();
        chk(rsp_err == e, e ? "R3 error response" : "R4/R8 normal response", rsp_err, e);
        if (rsp_err) chk(mem_cs == 8'h00, "R3 no chip select", mem_cs, 0);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) begin m_en = d[0]; m_mir = d[1]; m_lp = d[2]; end
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #3;
    chk(reg_rdata == exp, req, reg_rdata, exp);
    reg_sel = 1'b0;
  endtask

  task automatic drain();
    while (err_q.size() != 0 || !idle) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] cs, input bit wait_done);
    bit e;
    logic [2:0] m;
    @(negedge clk);
    while (!idle) @(negedge clk);
    e = !m_en || m_lp;
    m = (m_mir && (cs == 3'd0 || cs == 3'd4)) ? 3'd1 : cs;
    err_q.push_back(e);
    if (!e) cs_q.push_back(8'(1) << m);
    req_valid = 1'b1; req_cs = cs;
    @(negedge clk);
    req_valid = 1'b0;
    #4;
    chk(!idle && !req_ready, "R9 busy after accept", idle, 0);
    if (e) chk(rsp_valid && rsp_err, "R3 error one cycle after accept", rsp_valid, 1);
    if (wait_done) drain();
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int f0;
    rst_n = 1'b0; reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    req_valid = 0; req_cs = 0; mem_ready = 0; mem_done = 0;
    m_en = 1; m_mir = 1; m_lp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(refresh_en == 1'b1, "R1 refresh_en", refresh_en, 1);
    chk(idle && req_ready, "R1 idle/ready", {idle, req_ready}, 3);
    rd(2'd0, 32'h3, "R1 control reset");
    rd(2'd1, 32'h0, "R1 status reset");

    // R6 mirror active after reset
    issue(3'd0, 1); issue(3'd4, 1); issue(3'd1, 1); issue(3'd3, 1);

    // R2 reserved bits, R6 mirror off
    wr(2'd0, 32'hFFFF_FFF9);
    rd(2'd0, 32'h1, "R2 reserved bits read 0");
    issue(3'd0, 1); issue(3'd4, 1); issue(3'd7, 1);

    // R7/R5/R3 low power
    wr(2'd0, 32'h5);
    chk(refresh_en == 1'b1, "R7 refresh in low power", refresh_en, 1);
    rd(2'd0, 32'h5, "R5 read in low power");
    f0 = fwd_cnt;
    issue(3'd2, 1);
    chk(fwd_cnt == f0, "R3 low power not forwarded", fwd_cnt, f0);

    // disabled + low power, then disabled only
    wr(2'd0, 32'h4);
    chk(refresh_en == 1'b0, "R7 refresh stops when disabled", refresh_en, 0);
    issue(3'd5, 1);
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h0, "R5 read when disabled");
    f0 = fwd_cnt;
    issue(3'd6, 1);
    chk(fwd_cnt == f0, "R3 disabled not forwarded", fwd_cnt, f0);
    rd(2'd1, 32'h0, "R10 idle writes leave status clear");

    // re-enable, normal
    wr(2'd0, 32'h1);
    chk(refresh_en == 1'b1, "R7 refresh resumes", refresh_en, 1);
    issue(3'd5, 1);

    // R8/R10 mode change while in flight
    issue(3'd6, 0);
    wr(2'd0, 32'h0);
    drain();
    rd(2'd1, 32'h1, "R10 violation flagged");
    rd(2'd0, 32'h0, "R10 write applied");
    issue(3'd6, 1);
    wr(2'd1, 32'h1);
    rd(2'd1, 32'h0, "R10 status cleared");

    // mirror-only change in flight does not flag
    wr(2'd0, 32'h1);
    issue(3'd2, 0);
    wr(2'd0, 32'h3);
    drain();
    rd(2'd1, 32'h0, "R10 mirror change not flagged");
    issue(3'd4, 1);

    chk(err_q.size() == 0 && cs_q.size() == 0, "R9 all responses seen",
        err_q.size() + cs_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule